// File: doc/BRIEF.md
# Dual-Role Port Termination Arbiter

This block decides whether a dual-role connector port acts as the power source or the power sink. While nothing is attached it switches its termination on both CC pins back and forth. For part of a fixed period it shows pull-ups, which makes it look like a source. For the rest of the period it shows pull-downs, which makes it look like a sink. It watches two already-debounced status vectors that report, pin by pin, whether the far end shows a pull-down or a pull-up. When the matching status holds long enough, it commits to a role. It stays in that role until the far end's termination has been gone for a detach time.

A preference input favours the source role. A port with this preference that first qualifies as a sink switches to pull-ups for a bounded trial window. It takes the source role if the partner answers with a pull-down. If the partner does not, it falls back to the sink role. A dead-battery input means local power is missing. It forces pull-downs on both pins, blocks every route into the source role and drops a source role that is already held. All time values are parameters counted in clock cycles. The defaults assume a 1 MHz clock, which gives a 75 ms toggle period with a 50 % source share.

Top module: `drp_port_ctrl`

## Requirements
- R1: While reset is low, both pins show pull-downs (rd_en = 2'b11), no pull-up is enabled (rp_en = 2'b00), and attached and src_role are 0.
- R2: When no partner is present, each toggle period starts with a sink phase of PERIOD_CYC - SRC_CYC cycles (rd_en = 2'b11, rp_en = 2'b00), counted from reset release. A source phase of SRC_CYC = PERIOD_CYC * SRC_DUTY_PCT / 100 cycles follows (rp_en = 2'b11, rd_en = 2'b00). On each pin exactly one of rp_en and rd_en is set at all times.
- R3: Suppose partner_rd is nonzero on either bit during a source phase and stays nonzero for ATTACH_DB_CYC cycles. The port then commits as source: attached = 1 and src_role = 1 take effect ATTACH_DB_CYC + 1 clock edges after the first edge that sampled the pull-down, and rp_en stays 2'b11.
- R4: Suppose partner_rp is nonzero on either bit during a sink phase and stays nonzero for ATTACH_DB_CYC cycles, with try_src_en = 0. The port then commits as sink in the same number of edges: attached = 1, src_role = 0, rd_en = 2'b11.
- R5: A partner indication shorter than ATTACH_DB_CYC cycles commits nothing. The port goes back to toggling and starts a fresh full sink phase.
- R6: With try_src_en = 1, a sink qualification does not attach. The port instead moves into a trial that shows pull-ups. If partner_rd then holds for ATTACH_DB_CYC cycles within the trial, the port commits as source.
- R7: If the trial runs its TRY_WIN_CYC cycles without that pull-down and partner_rp is still nonzero at the end, the port commits as sink.
- R8: An attached port returns to unattached toggling, in its sink phase, after the partner termination it relied on (pull-down when source, pull-up when sink) has been missing for DETACH_DB_CYC consecutive cycles. A shorter gap keeps the attachment.
- R9: While dead_batt = 1, rd_en = 2'b11 and rp_en = 2'b00 in the same cycle. No source phase or trial is entered, src_role is 0 from the next edge on, and a port in that state can still attach as sink.
- R10: Connect two ports to each other, one with try_src_en = 1 and one with try_src_en = 0, and take them out of reset at different times. They end with the preferring port attached as source and the other attached as sink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts use it |
| rst_n | input | 1 | Synchronous active-low reset |
| try_src_en | input | 1 | Prefer the source role through the trial window |
| dead_batt | input | 1 | Local supply absent; force pull-downs |
| partner_rd | input | 2 | Debounced per-pin flag: partner pull-down seen |
| partner_rp | input | 2 | Debounced per-pin flag: partner pull-up seen |
| rp_en | output | 2 | Per-pin pull-up switch enable |
| rd_en | output | 2 | Per-pin pull-down switch enable |
| src_role | output | 1 | 1 when attached as source |
| attached | output | 1 | 1 when a role is committed |

## Verification
Toggling is checked cycle by cycle over three periods with a duty other than 50 %, so that a swap of the two phase lengths shows up. Each attach case is run on both CC pins: a steady pull-down, a steady pull-up, a pull-up that changes to a pull-down once the trial begins, and a pull-up that stays through the trial. These runs separate the direct path to each role from the trial path and from the trial fallback. Pulses one cycle shorter than the attach and detach times confirm that the filters count in the right place. A pair of cross-connected ports, released from reset at every offset within a period in both orders, shows that the preference resolves the roles whichever port sees the other first.

// File: rtl/drp_pkg.sv
// Shared definitions for the dual-role port arbiter.
// Assumes exactly two CC pins per connector.
package drp_pkg;

    localparam int unsigned CC_PINS = 2;

    // Arbiter states; "AW" states qualify a partner before committing.
    typedef enum logic [2:0] {
        ST_UNATT_SNK = 3'd0,
        ST_AW_SNK    = 3'd1,
        ST_UNATT_SRC = 3'd2,
        ST_AW_SRC    = 3'd3,
        ST_TRY_SRC   = 3'd4,
        ST_ATT_SRC   = 3'd5,
        ST_ATT_SNK   = 3'd6
    } drp_state_e;

    // True for every state that presents pull-ups on the pins.
    function automatic logic shows_pullup(drp_state_e s);
        return (s == ST_UNATT_SRC) || (s == ST_AW_SRC) ||
               (s == ST_TRY_SRC)   || (s == ST_ATT_SRC);
    endfunction

endpackage

// File: rtl/drp_dwell_timer.sv
// Counts cycles spent in the current state and flags when a limit is met.
// Assumes: clr is pulsed on every state change; lim_m1 is the limit minus
// one. The count stops at the limit, so expire stays high until cleared.
module drp_dwell_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim_m1,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    // Limit reached once the count stands at limit minus one.
    always_comb begin
        expire = (cnt >= lim_m1);
    end

    // Dwell counter: cleared on reset or state change, holds at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/drp_persist_filter.sv
// Fires when its input has been high for DEPTH consecutive cycles.
// Assumes: clr restarts the run (used on every state change); hit is
// combinational and is high in the DEPTH-th consecutive high cycle.
module drp_persist_filter #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level,
    output logic hit
);

    localparam int unsigned CW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] run;

    // Condition met when the current high cycle completes the run.
    always_comb begin
        hit = level && (run == LAST);
    end

    // Run-length counter of consecutive high cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !level) begin
            run <= '0;
        end else if (run != LAST) begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/drp_role_fsm.sv
// Role arbitration state machine for a dual-role port.
// Assumes: partner flags are already synchronised and debounced; the dwell
// timer and the two persistence filters are cleared through clr whenever
// the state changes. Priority in every state that shows pull-ups: dead
// battery first, then qualification, then timeouts.
module drp_role_fsm
    import drp_pkg::*;
#(
    parameter int unsigned TMR_W   = 17,
    parameter int unsigned SNK_CYC = 37500,
    parameter int unsigned SRC_CYC = 37500,
    parameter int unsigned TRY_CYC = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               try_src_en,
    input  logic               dead_batt,
    input  logic [CC_PINS-1:0] partner_rd,
    input  logic [CC_PINS-1:0] partner_rp,
    input  logic               expire,
    input  logic               att_hit,
    input  logic               det_hit,
    output logic               sense,
    output logic               clr,
    output logic [TMR_W-1:0]   lim_m1,
    output logic               rp_pres,
    output logic               src_role,
    output logic               attached
);

    localparam logic [TMR_W-1:0] SNK_M1 = TMR_W'(SNK_CYC - 1);
    localparam logic [TMR_W-1:0] SRC_M1 = TMR_W'(SRC_CYC - 1);
    localparam logic [TMR_W-1:0] TRY_M1 = TMR_W'(TRY_CYC - 1);

    drp_state_e st;
    drp_state_e st_nxt;
    logic       any_rd;
    logic       any_rp;

    // Reduce per-pin partner flags; orientation does not affect the role.
    always_comb begin
        any_rd = |partner_rd;
        any_rp = |partner_rp;
        sense  = shows_pullup(st) ? any_rd : any_rp;
    end

    // Dwell limit for the timed states; others never consult the timer.
    always_comb begin
        unique case (st)
            ST_UNATT_SRC: lim_m1 = SRC_M1;
            ST_TRY_SRC:   lim_m1 = TRY_M1;
            default:      lim_m1 = SNK_M1;
        endcase
    end

    // Next-state decision.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_UNATT_SNK: begin
                if (sense) begin
                    st_nxt = ST_AW_SNK;
                end else if (expire && !dead_batt) begin
                    st_nxt = ST_UNATT_SRC;
                end
            end
            ST_AW_SNK: begin
                if (!sense) begin
                    st_nxt = ST_UNATT_SNK;
                end else if (att_hit) begin
                    st_nxt = (try_src_en && !dead_batt) ? ST_TRY_SRC : ST_ATT_SNK;
                end
            end
            ST_UNATT_SRC: begin
                if (dead_batt) begin
                    st_nxt = ST_UNATT_SNK;
                end else if (sense) begin
                    st_nxt = ST_AW_SRC;
                end else if (expire) begin
                    st_nxt = ST_UNATT_SNK;
                end
            end
            ST_AW_SRC: begin
                if (dead_batt) begin
                    st_nxt = ST_UNATT_SNK;
                end else if (!sense) begin
                    st_nxt = ST_UNATT_SRC;
                end else if (att_hit) begin
                    st_nxt = ST_ATT_SRC;
                end
            end
            ST_TRY_SRC: begin
                if (dead_batt || (expire && !att_hit)) begin
                    st_nxt = any_rp ? ST_ATT_SNK : ST_UNATT_SNK;
                end else if (att_hit) begin
                    st_nxt = ST_ATT_SRC;
                end
            end
            ST_ATT_SRC: begin
                if (dead_batt || det_hit) begin
                    st_nxt = ST_UNATT_SNK;
                end
            end
            ST_ATT_SNK: begin
                if (det_hit) begin
                    st_nxt = ST_UNATT_SNK;
                end
            end
            default: st_nxt = ST_UNATT_SNK;
        endcase
    end

    // Restart the timer and filters whenever the state moves.
    always_comb begin
        clr = (st_nxt != st);
    end

    // State register; reset lands in the sink phase (pull-downs shown).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_UNATT_SNK;
        end else begin
            st <= st_nxt;
        end
    end

    // Role outputs; the dead-battery override acts in the same cycle.
    always_comb begin
        rp_pres  = shows_pullup(st) && !dead_batt;
        src_role = (st == ST_ATT_SRC);
        attached = (st == ST_ATT_SRC) || (st == ST_ATT_SNK);
    end

endmodule

// File: rtl/drp_port_ctrl.sv
// Dual-role port termination arbiter (top).
// Toggles pull-up and pull-down terminations while unattached, qualifies
// a partner with a persistence filter, optionally tries the source role,
// and drops back to toggling after a detach time. All times are in clock
// cycles; the defaults assume a 1 MHz clock.
// Assumes partner_rd / partner_rp are already debounced and synchronous.
module drp_port_ctrl #(
    parameter int unsigned PERIOD_CYC    = 75000,
    parameter int unsigned SRC_DUTY_PCT  = 50,
    parameter int unsigned ATTACH_DB_CYC = 150000,
    parameter int unsigned DETACH_DB_CYC = 15000,
    parameter int unsigned TRY_WIN_CYC   = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       try_src_en,
    input  logic       dead_batt,
    input  logic [1:0] partner_rd,
    input  logic [1:0] partner_rp,
    output logic [1:0] rp_en,
    output logic [1:0] rd_en,
    output logic       src_role,
    output logic       attached
);

    localparam int unsigned SRC_CYC = (PERIOD_CYC * SRC_DUTY_PCT) / 100;
    localparam int unsigned SNK_CYC = PERIOD_CYC - SRC_CYC;
    localparam int unsigned MAX_A   = (SNK_CYC > SRC_CYC) ? SNK_CYC : SRC_CYC;
    localparam int unsigned TMR_MAX = (MAX_A > TRY_WIN_CYC) ? MAX_A : TRY_WIN_CYC;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    logic             sense;
    logic             clr;
    logic             expire;
    logic             att_hit;
    logic             det_hit;
    logic             rp_pres;
    logic [TMR_W-1:0] lim_m1;

    drp_role_fsm #(
        .TMR_W   (TMR_W),
        .SNK_CYC (SNK_CYC),
        .SRC_CYC (SRC_CYC),
        .TRY_CYC (TRY_WIN_CYC)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .try_src_en (try_src_en),
        .dead_batt  (dead_batt),
        .partner_rd (partner_rd),
        .partner_rp (partner_rp),
        .expire     (expire),
        .att_hit    (att_hit),
        .det_hit    (det_hit),
        .sense      (sense),
        .clr        (clr),
        .lim_m1     (lim_m1),
        .rp_pres    (rp_pres),
        .src_role   (src_role),
        .attached   (attached)
    );

    drp_dwell_timer #(
        .CNT_W (TMR_W)
    ) i_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .lim_m1 (lim_m1),
        .expire (expire)
    );

    drp_persist_filter #(
        .DEPTH (ATTACH_DB_CYC)
    ) i_att_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .level (sense),
        .hit   (att_hit)
    );

    drp_persist_filter #(
        .DEPTH (DETACH_DB_CYC)
    ) i_det_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .level (!sense),
        .hit   (det_hit)
    );

    // Per-pin switch drive: both pins carry the same termination.
    for (genvar g = 0; g < int'(drp_pkg::CC_PINS); g++) begin : g_pin
        assign rp_en[g] = rp_pres;
        assign rd_en[g] = !rp_pres;
    end

endmodule

// File: rtl/drp_port_ctrl_chk.sv
// Property checker for drp_port_ctrl, attached by bind below.
// Observes ports only.
module drp_port_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dead_batt,
    input logic [1:0] partner_rd,
    input logic [1:0] partner_rp,
    input logic [1:0] rp_en,
    input logic [1:0] rd_en,
    input logic       src_role,
    input logic       attached
);

    AST_ONE_TERM_PER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((rp_en & rd_en) == 2'b00) && ((rp_en | rd_en) == 2'b11)); // R2

    AST_SRC_KEEPS_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (attached && src_role && !dead_batt) |-> (rp_en == 2'b11)); // R3

    AST_SRC_COMMIT_SAW_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attached && src_role) |-> $past(|partner_rd)); // R3

    AST_SNK_KEEPS_PULLDN: assert property (@(posedge clk) disable iff (!rst_n)
        (attached && !src_role) |-> (rd_en == 2'b11)); // R4

    AST_SNK_COMMIT_SAW_RP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(attached && !src_role) |-> $past(|partner_rp)); // R4

    AST_DEAD_FORCES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        dead_batt |-> ((rd_en == 2'b11) && (rp_en == 2'b00))); // R9

    AST_DEAD_NO_SRC_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        dead_batt |=> !src_role); // R9

endmodule

bind drp_port_ctrl drp_port_ctrl_chk i_drp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dead_batt  (dead_batt),
    .partner_rd (partner_rd),
    .partner_rp (partner_rp),
    .rp_en      (rp_en),
    .rd_en      (rd_en),
    .src_role   (src_role),
    .attached   (attached)
);

// File: tb/test_drp_port_ctrl.sv
// Bench: period 20, source duty 40 % (8 source / 12 sink), attach 4,
// detach 3, trial 12 cycles.
module test_drp_port_ctrl;

    localparam int PER = 20;
    localparam int DUTY = 40;
    localparam int ADB = 4;
    localparam int DDB = 3;
    localparam int TRY = 12;
    localparam int SRCC = PER * DUTY / 100;
    localparam int SNKC = PER - SRCC;

    // Status packing {rp_en, rd_en, attached, src_role}.
    localparam logic [5:0] U_SNK = 6'b00_11_0_0;
    localparam logic [5:0] U_SRC = 6'b11_00_0_0;
    localparam logic [5:0] A_SRC = 6'b11_00_1_1;
    localparam logic [5:0] A_SNK = 6'b00_11_1_0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       try_src_en = 1'b0;
    logic       dead_batt = 1'b0;
    logic [1:0] partner_rd = 2'b00;
    logic [1:0] partner_rp = 2'b00;
    logic [1:0] rp_en, rd_en;
    logic       src_role, attached;

    logic       rst_a_n = 1'b0;
    logic       rst_b_n = 1'b0;
    logic [1:0] a_rp, a_rd, b_rp, b_rd;
    logic       a_src, a_att, b_src, b_att;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    drp_port_ctrl #(
        .PERIOD_CYC(PER), .SRC_DUTY_PCT(DUTY), .ATTACH_DB_CYC(ADB),
        .DETACH_DB_CYC(DDB), .TRY_WIN_CYC(TRY)
    ) i_drp_port_ctrl (
        .clk(clk), .rst_n(rst_n), .try_src_en(try_src_en), .dead_batt(dead_batt),
        .partner_rd(partner_rd), .partner_rp(partner_rp),
        .rp_en(rp_en), .rd_en(rd_en), .src_role(src_role), .attached(attached)
    );

    // Pair of ports wired to each other with a flipped cable.
    drp_port_ctrl #(
        .PERIOD_CYC(PER), .SRC_DUTY_PCT(DUTY), .ATTACH_DB_CYC(ADB),
        .DETACH_DB_CYC(DDB), .TRY_WIN_CYC(TRY)
    ) i_port_a (
        .clk(clk), .rst_n(rst_a_n), .try_src_en(1'b1), .dead_batt(1'b0),
        .partner_rd({b_rd[0], b_rd[1]}), .partner_rp({b_rp[0], b_rp[1]}),
        .rp_en(a_rp), .rd_en(a_rd), .src_role(a_src), .attached(a_att)
    );

    drp_port_ctrl #(
        .PERIOD_CYC(PER), .SRC_DUTY_PCT(DUTY), .ATTACH_DB_CYC(ADB),
        .DETACH_DB_CYC(DDB), .TRY_WIN_CYC(TRY)
    ) i_port_b (
        .clk(clk), .rst_n(rst_b_n), .try_src_en(1'b0), .dead_batt(1'b0),
        .partner_rd({a_rd[0], a_rd[1]}), .partner_rp({a_rp[0], a_rp[1]}),
        .rp_en(b_rp), .rd_en(b_rd), .src_role(b_src), .attached(b_att)
    );

    function automatic logic [5:0] stat();
        return {rp_en, rd_en, attached, src_role};
    endfunction

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Advance n clock edges and settle 2 ns past the last one.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Apply inputs, hold reset, check the reset state, release ("edge 0").
    task automatic do_reset(input logic pf, input logic db, input logic [1:0] rd,
                            input logic [1:0] rp);
        try_src_en = pf;
        dead_batt  = db;
        partner_rd = rd;
        partner_rp = rp;
        rst_n = 1'b0;
        step(3);
        chk("R1 reset state", stat(), U_SNK);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all R): actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R2: three periods with no partner, checked every cycle.
        do_reset(1'b0, 1'b0, 2'b00, 2'b00);
        for (int j = 1; j <= 3 * PER; j++) begin
            step(1);
            chk("R2 toggle phase", stat(), ((j % PER) >= SNKC) ? U_SRC : U_SNK);
        end

        // R3 on both pins, with and without preference, then R8 detach.
        for (int k = 0; k < 2; k++) begin
            for (int pf = 0; pf < 2; pf++) begin
                do_reset(pf[0], 1'b0, 2'(1 << k), 2'b00);
                step(SNKC + ADB);
                chk("R3 still qualifying", stat(), U_SRC);
                step(1);
                chk("R3 attached as source", stat(), A_SRC);
                partner_rd = 2'b00;
                step(DDB - 1);
                chk("R8 source held before detach time", stat(), A_SRC);
                step(1);
                chk("R8 source detached", stat(), U_SNK);
            end
        end

        // R4 on both pins, then a detach gap one cycle short (R8).
        for (int k = 0; k < 2; k++) begin
            do_reset(1'b0, 1'b0, 2'b00, 2'(1 << k));
            step(ADB);
            chk("R4 still qualifying", stat(), U_SNK);
            step(1);
            chk("R4 attached as sink", stat(), A_SNK);
            partner_rp = 2'b00;
            step(DDB - 1);
            partner_rp = 2'(1 << k);
            step(1);
            chk("R8 short gap ignored", stat(), A_SNK);
            step(3);
            chk("R8 sink still held", stat(), A_SNK);
        end

        // R5: pull-up pulse too short; toggling restarts with a full sink phase.
        do_reset(1'b0, 1'b0, 2'b00, 2'b01);
        step(2);
        partner_rp = 2'b00;
        for (int j = 3; j <= 2 + SNKC; j++) begin
            step(1);
            chk("R5 short pulse not committed", stat(), U_SNK);
        end
        step(1);
        chk("R5 toggling resumed", stat(), U_SRC);

        // R6: trial answered by a pull-down.
        for (int k = 0; k < 2; k++) begin
            do_reset(1'b1, 1'b0, 2'b00, 2'(1 << k));
            step(ADB + 1);
            chk("R6 trial shows pull-ups", stat(), U_SRC);
            partner_rp = 2'b00;
            partner_rd = 2'(1 << k);
            step(ADB - 1);
            chk("R6 trial still qualifying", stat(), U_SRC);
            step(1);
            chk("R6 trial won source", stat(), A_SRC);
        end

        // R7: trial unanswered, partner still a source.
        for (int k = 0; k < 2; k++) begin
            do_reset(1'b1, 1'b0, 2'b00, 2'(1 << k));
            step(ADB + TRY);
            chk("R7 trial running", stat(), U_SRC);
            step(1);
            chk("R7 fallback to sink", stat(), A_SNK);
        end

        // R9: dead battery with a sink partner: never toggles or attaches.
        do_reset(1'b1, 1'b1, 2'b01, 2'b00);
        for (int j = 1; j <= 2 * PER; j++) begin
            step(1);
            chk("R9 dead battery holds pull-downs", stat(), U_SNK);
        end
        // R9: dead battery with a source partner attaches as sink, no trial.
        do_reset(1'b1, 1'b1, 2'b00, 2'b10);
        step(ADB);
        chk("R9 dead battery qualifying", stat(), U_SNK);
        step(1);
        chk("R9 dead battery sink attach", stat(), A_SNK);
        step(TRY);
        chk("R9 dead battery no trial", stat(), A_SNK);
        // R9: losing power while source drops pull-ups at once, role next edge.
        do_reset(1'b0, 1'b0, 2'b01, 2'b00);
        step(SNKC + ADB + 1);
        chk("R9 setup source attach", stat(), A_SRC);
        dead_batt = 1'b1;
        #1;
        chk("R9 pull-ups off same cycle", stat(), 6'b00_11_1_1);
        step(1);
        chk("R9 source role dropped", stat(), U_SNK);
        dead_batt = 1'b0;

        // R10: two ports, every release offset in both orders.
        for (int ord = 0; ord < 2; ord++) begin
            for (int d = 1; d < PER; d++) begin
                rst_a_n = 1'b0;
                rst_b_n = 1'b0;
                step(3);
                if (ord == 0) rst_a_n = 1'b1; else rst_b_n = 1'b1;
                step(d);
                rst_a_n = 1'b1;
                rst_b_n = 1'b1;
                step(200);
                chk("R10 preferring port is source",
                    {2'b00, a_att, a_src, b_att, b_src}, 6'b00_1_1_1_0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule